// File: doc/BRIEF.md
# Write-Through Store Drain Queue

This block sits between a write-through data cache and a slow main memory. Each store the processor makes goes into a short queue of address and data pairs. The processor carries on in the next cycle. The queue sends its oldest entry to memory over a request/acknowledge port. The head entry is held on that port until memory acknowledges it. Only then does the next entry come forward.

The processor is held back only when a new store arrives while every slot is occupied and memory does not take an entry in that same cycle. A read that missed in the cache first checks the queue. If one or more buffered stores target the same address, the data of the most recent of them is returned, so the read never sees stale memory. An empty flag lets a fence or flush sequence wait until every buffered store has reached memory.

Top module: `store_drain_queue`

## Requirements
- R1: Out of reset the queue holds nothing: `emptyOut` is 1, `memReq` is 0, and `stStall` and `rdHit` are 0.
- R2: A store offered (`stReq`=1) while fewer than DEPTH (default 4) entries are held is taken at that clock edge with `stStall`=0. When it is the only entry, it appears on `memAddr`/`memData` in the next cycle.
- R3: Entries go to memory in the order they were taken. The head's address and data stay unchanged on the memory port until a cycle with `memReq`=1 and `memAck`=1 removes it.
- R4: `stStall` is 1 in exactly those cycles where `stReq`=1, the queue holds DEPTH entries, and `memAck` is 0. A stalled store is not recorded, and the count never exceeds DEPTH.
- R5: When the queue is full, a store and an acknowledge in the same cycle are both taken, with `stStall`=0. The new store becomes the youngest entry.
- R6: If any held entry's address equals `rdAddr`, `rdHit` is 1 and `rdData` is the data of the most recently taken such entry. This is combinational in the same cycle.
- R7: If no held entry matches `rdAddr`, `rdHit` is 0 and `rdData` is 0. Entries already sent to memory are not matched.
- R8: `emptyOut` is 1 exactly when no entries are held, and `memReq` is its inverse.
- R9: `memAck` while `memReq`=0 is ignored: the queue stays empty.
- R10: At most one entry leaves per clock. With `memAck` held high, N entries take exactly N cycles to drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stReq | input | 1 | Processor store request |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| stStall | output | 1 | Store not taken this cycle; hold it and retry |
| rdAddr | input | AW | Read-miss address to check against the queue |
| rdHit | output | 1 | A held entry matches `rdAddr` |
| rdData | output | DW | Youngest matching data, 0 when no match |
| memReq | output | 1 | Head entry offered to memory |
| memAddr | output | AW | Head entry address |
| memData | output | DW | Head entry data |
| memAck | input | 1 | Memory takes the head entry this cycle |
| emptyOut | output | 1 | No stores pending |

## Verification
Single stores, a full queue with a stalled extra store, and a full queue with a store and an acknowledge together are driven. Between them they separate the case of not stalling at all, stalling too early or too late, and losing or keeping the stalled data. A sequence that stores the same address twice, with another address in between, shows whether forwarding picks the youngest match, the oldest match, or keeps matching entries that have already drained. A held acknowledge over three entries separates a one-per-cycle drain from a skipped or repeated head. An acknowledge on an empty queue checks that the count cannot underflow.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  // strobes sent from the control to the datapath
  typedef struct packed {
    logic push;  // write the store into the tail slot
    logic pop;   // head slot accepted by memory
  } sdq_strobe_t;
endpackage

// File: rtl/sdq_ctrl.sv
module sdq_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stReq,
  input  logic                 memAck,
  output sdq_pkg::sdq_strobe_t strb,
  output logic [PW-1:0]        wrIdx,
  output logic [PW-1:0]        hdIdx,
  output logic [CW-1:0]        occ,
  output logic                 stStall,
  output logic                 memReq,
  output logic                 emptyOut
);
  logic isFull;
  logic isEmpty;

  function automatic logic [PW-1:0] nextIdx(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    isFull    = (occ == CW'(DEPTH));
    isEmpty   = (occ == '0);
    strb.pop  = !isEmpty && memAck;
    strb.push = stReq && (!isFull || strb.pop);
    stStall   = stReq && !strb.push;
    memReq    = !isEmpty;
    emptyOut  = isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      hdIdx <= '0;
      occ   <= '0;
    end else begin
      if (strb.push) wrIdx <= nextIdx(wrIdx);
      if (strb.pop)  hdIdx <= nextIdx(hdIdx);
      if (strb.push && !strb.pop)      occ <= occ + CW'(1);
      else if (strb.pop && !strb.push) occ <= occ - CW'(1);
    end
  end

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occ <= CW'(DEPTH));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stStall |=> $stable(occ));

  // R10
  one_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> (occ == $past(occ) - CW'(1)));

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && memAck && !stReq) |=> (occ == '0));
endmodule

// File: rtl/sdq_data.sv
module sdq_data #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sdq_pkg::sdq_strobe_t strb,
  input  logic [PW-1:0]        wrIdx,
  input  logic [PW-1:0]        hdIdx,
  input  logic [CW-1:0]        occ,
  input  logic [AW-1:0]        stAddr,
  input  logic [DW-1:0]        stData,
  input  logic [AW-1:0]        rdAddr,
  output logic [AW-1:0]        memAddr,
  output logic [DW-1:0]        memData,
  output logic                 rdHit,
  output logic [DW-1:0]        rdData
);
  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];

  // slot holding the entry of the given age (0 = oldest)
  function automatic logic [PW-1:0] ageIdx(input logic [PW-1:0] hd, input int age);
    int pos;
    pos = int'(hd) + age;
    if (pos >= DEPTH) pos = pos - DEPTH;
    return PW'(pos);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
      end
    end else if (strb.push) begin
      addrQ[wrIdx] <= stAddr;
      dataQ[wrIdx] <= stData;
    end
  end

  assign memAddr = addrQ[hdIdx];
  assign memData = dataQ[hdIdx];

  // walk from oldest to youngest so a later match overrides an earlier one
  always_comb begin
    rdHit  = 1'b0;
    rdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < occ) && (addrQ[ageIdx(hdIdx, i)] == rdAddr)) begin
        rdHit  = 1'b1;
        rdData = dataQ[ageIdx(hdIdx, i)];
      end
    end
  end

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((occ != '0) && !strb.pop) |=> ($stable(memAddr) && $stable(memData)));

  // R7
  fwd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |-> (occ != '0));
endmodule

// File: rtl/store_drain_queue.sv
module store_drain_queue #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stReq,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  output logic          stStall,
  input  logic [AW-1:0] rdAddr,
  output logic          rdHit,
  output logic [DW-1:0] rdData,
  output logic          memReq,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  input  logic          memAck,
  output logic          emptyOut
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  sdq_pkg::sdq_strobe_t strb;
  logic [PW-1:0] wrIdx;
  logic [PW-1:0] hdIdx;
  logic [CW-1:0] occ;

  sdq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stReq(stReq), .memAck(memAck),
    .strb(strb), .wrIdx(wrIdx), .hdIdx(hdIdx), .occ(occ),
    .stStall(stStall), .memReq(memReq), .emptyOut(emptyOut)
  );

  sdq_data #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .hdIdx(hdIdx),
    .occ(occ), .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr),
    .memAddr(memAddr), .memData(memData), .rdHit(rdHit), .rdData(rdData)
  );

  // R8
  empty_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    emptyOut |-> !memReq);
endmodule

// File: tb/test_store_drain_queue.sv
module test_store_drain_queue;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stReq = 1'b0;
  logic [AW-1:0] stAddr = '0;
  logic [DW-1:0] stData = '0;
  logic          stStall;
  logic [AW-1:0] rdAddr = '0;
  logic          rdHit;
  logic [DW-1:0] rdData;
  logic          memReq;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          memAck = 1'b0;
  logic          emptyOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_drain_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_drain_queue (
    .clk(clk), .rstN(rstN), .stReq(stReq), .stAddr(stAddr), .stData(stData),
    .stStall(stStall), .rdAddr(rdAddr), .rdHit(rdHit), .rdData(rdData),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck),
    .emptyOut(emptyOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pushOne(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic expStall, input string req);
    stReq = 1'b1; stAddr = a; stData = d;
    #1;
    check(req, 32'(stStall), 32'(expStall));
    step();
    stReq = 1'b0;
  endtask

  task automatic popOne(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    #1;
    check(req, 32'(memReq), 32'd1);
    check(req, 32'(memAddr), 32'(a));
    check(req, 32'(memData), 32'(d));
    memAck = 1'b1;
    step();
    memAck = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check("R1", 32'(emptyOut), 32'd1);
    check("R1", 32'(memReq), 32'd0);
    check("R1", 32'(stStall), 32'd0);
    check("R1", 32'(rdHit), 32'd0);
  endtask

  task automatic testSingle();
    memAck = 1'b1;               // R9: nothing to acknowledge
    step();
    memAck = 1'b0;
    #1;
    check("R9", 32'(emptyOut), 32'd1);
    check("R9", 32'(memReq), 32'd0);
    pushOne(16'h0010, 32'hA0, 1'b0, "R2");
    #1;
    check("R8", 32'(emptyOut), 32'd0);
    check("R8", 32'(memReq), 32'd1);
    check("R2", 32'(memAddr), 32'h10);
    popOne(16'h0010, 32'hA0, "R3");
    #1;
    check("R8", 32'(emptyOut), 32'd1);
  endtask

  task automatic testFullStall();
    for (int i = 0; i < DEPTH; i++) pushOne(AW'(16'h20 + i), DW'(32'hB0 + i), 1'b0, "R2");
    #1;
    check("R3", 32'(memAddr), 32'h20);
    pushOne(16'h0099, 32'hEE, 1'b1, "R4");
    pushOne(16'h0099, 32'hEE, 1'b1, "R4");
    for (int i = 0; i < DEPTH; i++) popOne(AW'(16'h20 + i), DW'(32'hB0 + i), "R3");
    #1;
    check("R4", 32'(emptyOut), 32'd1);  // stalled store was never recorded
  endtask

  task automatic testFullAck();
    for (int i = 0; i < DEPTH; i++) pushOne(AW'(16'h30 + i), DW'(32'hC0 + i), 1'b0, "R2");
    stReq = 1'b1; stAddr = 16'h0034; stData = 32'hC4; memAck = 1'b1;
    #1;
    check("R5", 32'(stStall), 32'd0);
    step();
    stReq = 1'b0; memAck = 1'b0;
    for (int i = 1; i <= DEPTH; i++) popOne(AW'(16'h30 + i), DW'(32'hC0 + i), "R5");
    #1;
    check("R5", 32'(emptyOut), 32'd1);
  endtask

  task automatic testForward();
    pushOne(16'h0040, 32'h1, 1'b0, "R2");
    pushOne(16'h0050, 32'h2, 1'b0, "R2");
    pushOne(16'h0040, 32'h3, 1'b0, "R2");
    rdAddr = 16'h0040; #1;
    check("R6", 32'(rdHit), 32'd1);
    check("R6", rdData, 32'h3);
    rdAddr = 16'h0050; #1;
    check("R6", 32'(rdHit), 32'd1);
    check("R6", rdData, 32'h2);
    rdAddr = 16'h0060; #1;
    check("R7", 32'(rdHit), 32'd0);
    check("R7", rdData, 32'h0);
    popOne(16'h0040, 32'h1, "R3");
    rdAddr = 16'h0040; #1;
    check("R6", rdData, 32'h3);
    popOne(16'h0050, 32'h2, "R3");
    popOne(16'h0040, 32'h3, "R3");
    #1;
    check("R7", 32'(rdHit), 32'd0);
    check("R7", rdData, 32'h0);
  endtask

  task automatic testBurst();
    for (int i = 0; i < 3; i++) pushOne(AW'(16'h70 + i), DW'(32'hD0 + i), 1'b0, "R2");
    memAck = 1'b1;
    #1;
    check("R10", 32'(memAddr), 32'h70);
    step(); #1;
    check("R10", 32'(memAddr), 32'h71);
    check("R10", 32'(emptyOut), 32'd0);
    step(); #1;
    check("R10", 32'(memAddr), 32'h72);
    check("R10", 32'(emptyOut), 32'd0);
    step(); #1;
    check("R10", 32'(emptyOut), 32'd1);
    step(); #1;
    check("R9", 32'(emptyOut), 32'd1);
    memAck = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    step();
    step();
    rstN = 1'b1;
    testReset();
    testSingle();
    testFullStall();
    testFullAck();
    testForward();
    testBurst();
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end
endmodule